// File: doc/BRIEF.md
# PHY Register Handshake Sequencer

This block is a hardware master for a PHY whose 16-bit internal registers are not memory-mapped. It reaches them through a 20-bit control word that it drives and a 17-bit status word that it samples. A client issues a read or a write with a 16-bit register address and, for a write, 16-bit data. The sequencer breaks the access into a chain of strobe phases. Each phase raises one strobe and waits for the PHY's acknowledge to go high. It then drops the strobe and waits for the acknowledge to go low.

Every acknowledge wait is bounded. The level is sampled at most `MAX_SAMPLES` times, with `SAMPLE_GAP` clock cycles between samples. If the expected level is never seen, the access stops with an error and the control word is cleared. At the end of an access the block pulses `done` for one cycle, with `err` valid in the same cycle. A successful read returns the value the PHY presented on the status word while it acknowledged the read strobe.

Top module: `phy_reg_seq`

## Requirements
- R1: While and after reset, `done`, `err`, `rd_data` and `phy_ctrl` are all zero.
- R2: Control word layout: bits 15:0 carry the address or data payload, bit 16 captures an address, bit 17 captures data, bit 18 is the write strobe and bit 19 is the read strobe. At most one of bits 19:16 is set at any time.
- R3: Address phase: the address is driven with all strobes low for one cycle. Then bit 16 is raised with the address held. Once ack is seen high, bit 16 drops while the address stays, and the block waits for ack low.
- R4: Write: address phase, then data driven with strobes low followed by a capture-data phase (ack high, then low), then a write-strobe phase (ack high, then low). Finally the control word is cleared to zero in the cycle `done` is high.
- R5: Read: address phase, then the read strobe alone. On ack high, status bits 15:0 are captured and the control word is cleared. After ack low, the captured value appears on `rd_data`. Status bit 16 is the ack.
- R6: Each ack wait samples on its first cycle and then every `SAMPLE_GAP` cycles, at most `MAX_SAMPLES` times. An ack seen at the last sample still succeeds. With no ack at all, `done` follows the request edge by 2 + (`MAX_SAMPLES`-1)·`SAMPLE_GAP` edges.
- R7: On a timeout in any phase, `done` and `err` pulse together, the control word is zero, and the block returns to idle ready for the next request.
- R8: A request is accepted only in idle. A request raised while an access is in progress has no effect.
- R9: `done` is high for exactly one cycle per accepted request, and `err` is never high without `done`.
- R10: `rd_data` changes only in the cycle where `done` is high with `err` low on a read. It holds across writes and failed accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Start an access (taken only when idle) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | PHY register address |
| req_wdata | input | 16 | Write data |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Timeout flag, valid with `done` |
| rd_data | output | 16 | Last successfully read value |
| phy_ctrl | output | 20 | Control word to the PHY |
| phy_stat | input | 17 | Status word from the PHY (bit 16 ack, 15:0 data) |

## Verification
Two functions can land in the same cycle. The first is the final sample of an ack wait, where the timeout decision and a late acknowledge arrive together. The bench provokes this with a responder whose acknowledge latency sits exactly on the last sample and then one cycle past it: the first access must succeed and the second must fail with the predicted latency. The second collision is a new request arriving while an access is running, which must lose to the access in flight. The bench judges it by reading both the target register and the poked register back afterwards.

// File: rtl/physeq_pkg.sv
`timescale 1ns/1ps
package physeq_pkg;

    localparam int PL_W     = 16;
    localparam int CTRL_W   = PL_W + 4;
    localparam int STAT_W   = PL_W + 1;
    localparam int CAPA_BIT = PL_W;
    localparam int CAPD_BIT = PL_W + 1;
    localparam int WR_BIT   = PL_W + 2;
    localparam int RD_BIT   = PL_W + 3;
    localparam int ACK_BIT  = PL_W;

    typedef enum logic [2:0] {
        STB_NONE,
        STB_CAPA,
        STB_CAPD,
        STB_WR,
        STB_RD
    } strobe_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_ADR_SET,
        S_ADR_HI,
        S_ADR_LO,
        S_DAT_SET,
        S_DAT_HI,
        S_DAT_LO,
        S_WR_HI,
        S_WR_LO,
        S_RD_HI,
        S_RD_LO
    } seq_state_e;

    typedef struct packed {
        logic            is_wr;
        logic [PL_W-1:0] addr;
        logic [PL_W-1:0] wdata;
    } cmd_t;

    function automatic logic [CTRL_W-1:0] ctrl_word(strobe_e s, logic [PL_W-1:0] pl);
        logic [CTRL_W-1:0] w;
        w = '0;
        w[PL_W-1:0] = pl;
        case (s)
            STB_CAPA: w[CAPA_BIT] = 1'b1;
            STB_CAPD: w[CAPD_BIT] = 1'b1;
            STB_WR:   w[WR_BIT]   = 1'b1;
            STB_RD:   w[RD_BIT]   = 1'b1;
            default:  ;
        endcase
        return w;
    endfunction

    function automatic logic is_wait(seq_state_e s);
        return (s == S_ADR_HI) || (s == S_ADR_LO) || (s == S_DAT_HI) ||
               (s == S_DAT_LO) || (s == S_WR_HI)  || (s == S_WR_LO)  ||
               (s == S_RD_HI)  || (s == S_RD_LO);
    endfunction

    function automatic logic wants_high(seq_state_e s);
        return (s == S_ADR_HI) || (s == S_DAT_HI) || (s == S_WR_HI) || (s == S_RD_HI);
    endfunction

endpackage

// File: rtl/physeq_ack_wait.sv
`timescale 1ns/1ps
module physeq_ack_wait #(
    parameter int SAMPLE_GAP  = 4,
    parameter int MAX_SAMPLES = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic active,
    input  logic want,
    input  logic ack,
    output logic hit,
    output logic expire
);
    localparam int GAP_W = (SAMPLE_GAP > 1) ? $clog2(SAMPLE_GAP) : 1;
    localparam int CNT_W = $clog2(MAX_SAMPLES + 1);

    logic [GAP_W-1:0] gap_cnt;
    logic [CNT_W-1:0] smp_cnt;
    logic             sample_now;
    logic             last_smp;

    assign sample_now = active && (gap_cnt == '0);
    assign last_smp   = (smp_cnt == CNT_W'(MAX_SAMPLES - 1));
    assign hit        = sample_now && (ack == want);
    assign expire     = sample_now && (ack != want) && last_smp;

    always_ff @(posedge clk) begin
        if (rst || !active || hit) begin
            gap_cnt <= '0;
            smp_cnt <= '0;
        end else if (gap_cnt == '0) begin
            smp_cnt <= smp_cnt + 1'b1;
            gap_cnt <= GAP_W'(SAMPLE_GAP - 1);
        end else begin
            gap_cnt <= gap_cnt - 1'b1;
        end
    end

endmodule

// File: rtl/physeq_fsm.sv
`timescale 1ns/1ps
module physeq_fsm
    import physeq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  cmd_t              req_cmd,
    input  logic [PL_W-1:0]   stat_data,
    input  logic              hit,
    input  logic              expire,
    output logic              wait_active,
    output logic              wait_want,
    output logic [CTRL_W-1:0] ctrl,
    output logic              done,
    output logic              err,
    output logic [PL_W-1:0]   rd_data
);
    seq_state_e      state;
    cmd_t            cmd;
    logic [PL_W-1:0] rd_cap;

    assign wait_active = is_wait(state);
    assign wait_want   = wants_high(state);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= S_IDLE;
            cmd     <= '0;
            rd_cap  <= '0;
            rd_data <= '0;
            ctrl    <= '0;
            done    <= 1'b0;
            err     <= 1'b0;
        end else begin
            done <= 1'b0;
            err  <= 1'b0;
            if (state == S_IDLE) begin
                if (req) begin
                    cmd   <= req_cmd;
                    ctrl  <= ctrl_word(STB_NONE, req_cmd.addr);
                    state <= S_ADR_SET;
                end
            end else if (state == S_ADR_SET) begin
                ctrl  <= ctrl_word(STB_CAPA, cmd.addr);
                state <= S_ADR_HI;
            end else if (state == S_DAT_SET) begin
                ctrl  <= ctrl_word(STB_CAPD, cmd.wdata);
                state <= S_DAT_HI;
            end else if (expire) begin
                ctrl  <= '0;
                done  <= 1'b1;
                err   <= 1'b1;
                state <= S_IDLE;
            end else if (hit) begin
                case (state)
                    S_ADR_HI: begin
                        ctrl  <= ctrl_word(STB_NONE, cmd.addr);
                        state <= S_ADR_LO;
                    end
                    S_ADR_LO: begin
                        if (cmd.is_wr) begin
                            ctrl  <= ctrl_word(STB_NONE, cmd.wdata);
                            state <= S_DAT_SET;
                        end else begin
                            ctrl  <= ctrl_word(STB_RD, '0);
                            state <= S_RD_HI;
                        end
                    end
                    S_DAT_HI: begin
                        ctrl  <= ctrl_word(STB_NONE, cmd.wdata);
                        state <= S_DAT_LO;
                    end
                    S_DAT_LO: begin
                        ctrl  <= ctrl_word(STB_WR, '0);
                        state <= S_WR_HI;
                    end
                    S_WR_HI: begin
                        ctrl  <= ctrl_word(STB_NONE, cmd.wdata);
                        state <= S_WR_LO;
                    end
                    S_WR_LO: begin
                        ctrl  <= '0;
                        done  <= 1'b1;
                        state <= S_IDLE;
                    end
                    S_RD_HI: begin
                        rd_cap <= stat_data;
                        ctrl   <= '0;
                        state  <= S_RD_LO;
                    end
                    S_RD_LO: begin
                        rd_data <= rd_cap;
                        done    <= 1'b1;
                        state   <= S_IDLE;
                    end
                    default: state <= S_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/phy_reg_seq.sv
`timescale 1ns/1ps
module phy_reg_seq
    import physeq_pkg::*;
#(
    parameter int SAMPLE_GAP  = 4,
    parameter int MAX_SAMPLES = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              req_write,
    input  logic [PL_W-1:0]   req_addr,
    input  logic [PL_W-1:0]   req_wdata,
    output logic              done,
    output logic              err,
    output logic [PL_W-1:0]   rd_data,
    output logic [CTRL_W-1:0] phy_ctrl,
    input  logic [STAT_W-1:0] phy_stat
);
    cmd_t req_cmd;
    logic wait_active;
    logic wait_want;
    logic hit;
    logic expire;

    assign req_cmd = '{is_wr: req_write, addr: req_addr, wdata: req_wdata};

    physeq_ack_wait #(
        .SAMPLE_GAP  (SAMPLE_GAP),
        .MAX_SAMPLES (MAX_SAMPLES)
    ) waiter_i (
        .clk    (clk),
        .rst    (rst),
        .active (wait_active),
        .want   (wait_want),
        .ack    (phy_stat[ACK_BIT]),
        .hit    (hit),
        .expire (expire)
    );

    physeq_fsm fsm_i (
        .clk         (clk),
        .rst         (rst),
        .req         (req),
        .req_cmd     (req_cmd),
        .stat_data   (phy_stat[PL_W-1:0]),
        .hit         (hit),
        .expire      (expire),
        .wait_active (wait_active),
        .wait_want   (wait_want),
        .ctrl        (phy_ctrl),
        .done        (done),
        .err         (err),
        .rd_data     (rd_data)
    );

endmodule

// File: rtl/phy_reg_seq_chk.sv
`timescale 1ns/1ps
module phy_reg_seq_chk
    import physeq_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              done,
    input logic              err,
    input logic [PL_W-1:0]   rd_data,
    input logic [CTRL_W-1:0] phy_ctrl
);
    // R2: never two strobes together
    p_single_strobe_r2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(phy_ctrl[CTRL_W-1:PL_W]));

    // R3: capture-address rises only after a cycle of payload with strobes low
    p_capa_setup_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(phy_ctrl[CAPA_BIT]) |->
            ($past(phy_ctrl[CTRL_W-1:PL_W]) == '0) && $stable(phy_ctrl[PL_W-1:0]));

    // R4: capture-data rises only after a cycle of payload with strobes low
    p_capd_setup_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(phy_ctrl[CAPD_BIT]) |->
            ($past(phy_ctrl[CTRL_W-1:PL_W]) == '0) && $stable(phy_ctrl[PL_W-1:0]));

    // R7: control word is zero whenever an access ends
    p_ctrl_clear_r7: assert property (@(posedge clk) disable iff (rst)
        done |-> (phy_ctrl == '0));

    // R9: done is a single-cycle pulse
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9: err only alongside done
    p_err_with_done_r9: assert property (@(posedge clk) disable iff (rst)
        err |-> done);

    // R10: read data moves only on a successful completion
    p_rdata_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (!done || err) |-> $stable(rd_data));

endmodule

bind phy_reg_seq phy_reg_seq_chk chk_i (
    .clk      (clk),
    .rst      (rst),
    .done     (done),
    .err      (err),
    .rd_data  (rd_data),
    .phy_ctrl (phy_ctrl)
);

// File: tb/phy_reg_seq_tb_top.sv
`timescale 1ns/1ps
module phy_reg_seq_tb_top;
    import physeq_pkg::*;

    localparam int G  = 3;
    localparam int MX = 10;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req = 1'b0;
    logic              req_write = 1'b0;
    logic [PL_W-1:0]   req_addr = '0;
    logic [PL_W-1:0]   req_wdata = '0;
    logic              done;
    logic              err;
    logic [PL_W-1:0]   rd_data;
    logic [CTRL_W-1:0] phy_ctrl;
    logic [STAT_W-1:0] phy_stat;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    phy_reg_seq #(.SAMPLE_GAP(G), .MAX_SAMPLES(MX)) dut_i (
        .clk(clk), .rst(rst), .req(req), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .done(done), .err(err),
        .rd_data(rd_data), .phy_ctrl(phy_ctrl), .phy_stat(phy_stat)
    );

    // ---------------- behavioural PHY responder ----------------
    int              dly = 0;
    int              mode = 0;      // 0 normal, 1 never acks, 2 ack never falls
    int              cnt = 0;
    logic            ack = 1'b0;
    logic [PL_W-1:0] sdata = '0;
    logic [PL_W-1:0] addr_cap = '0;
    logic [PL_W-1:0] data_cap = '0;
    logic [PL_W-1:0] mem [16];
    logic [CTRL_W-1:0] prev_ctrl = '0;
    bit              data_fresh = 0;
    int              prot_err = 0;

    assign phy_stat = {ack, sdata};

    initial for (int i = 0; i < 16; i++) mem[i] = '0;

    always @(posedge clk) begin
        prev_ctrl <= phy_ctrl;
        if (phy_ctrl[CAPA_BIT] && !prev_ctrl[CAPA_BIT] &&
            (prev_ctrl[CTRL_W-1:PL_W] != '0 || prev_ctrl[PL_W-1:0] != phy_ctrl[PL_W-1:0]))
            prot_err <= prot_err + 1;
        if (phy_ctrl[WR_BIT] && !prev_ctrl[WR_BIT] && !data_fresh)
            prot_err <= prot_err + 1;
        if (mode == 1) begin
            ack <= 1'b0;
            cnt <= 0;
        end else if ((phy_ctrl[CTRL_W-1:PL_W] != '0) && !ack) begin
            if (cnt >= dly) begin
                ack <= 1'b1;
                cnt <= 0;
                if (phy_ctrl[CAPA_BIT]) begin addr_cap <= phy_ctrl[PL_W-1:0]; data_fresh <= 0; end
                if (phy_ctrl[CAPD_BIT]) begin data_cap <= phy_ctrl[PL_W-1:0]; data_fresh <= 1; end
                if (phy_ctrl[WR_BIT])   mem[addr_cap[3:0]] <= data_cap;
                if (phy_ctrl[RD_BIT])   sdata <= mem[addr_cap[3:0]];
            end else cnt <= cnt + 1;
        end else if ((phy_ctrl[CTRL_W-1:PL_W] == '0) && ack) begin
            if (mode == 2) cnt <= 0;
            else if (cnt >= dly) begin ack <= 1'b0; cnt <= 0; end
            else cnt <= cnt + 1;
        end else cnt <= 0;
    end

    // ---------------- checking helpers ----------------
    task automatic chk(input bit ok, input string req_tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req_tag, what, act, exp);
        end
    endtask

    task automatic op(input bit wr, input logic [PL_W-1:0] a, input logic [PL_W-1:0] wd,
                      input bit poke, output bit e, output logic [PL_W-1:0] rd, output int n);
        @(negedge clk);
        req = 1'b1; req_write = wr; req_addr = a; req_wdata = wd;
        @(negedge clk);
        req = 1'b0;
        n = 1;
        while (!done && n < 400) begin
            if (poke && n == 5) begin
                req = 1'b1; req_write = 1'b1; req_addr = a ^ 16'h0008; req_wdata = ~wd;
            end else req = 1'b0;
            @(negedge clk);
            n++;
        end
        req = 1'b0;
        e = err;
        rd = rd_data;
        chk(phy_ctrl == '0, "R4", "control word at done", 32'(phy_ctrl), 0);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(!done && !err, "R9", "done/err after completion", {30'd0, done, err}, 0);
        end
    endtask

    function automatic int lat_read(input int d);
        int h;
        h = ((d + G) / G) * G;
        return 6 + 4 * h;
    endfunction

    logic [PL_W-1:0] exp_mem [16];
    logic [PL_W-1:0] last_rd;

    initial begin
        bit              e;
        logic [PL_W-1:0] rd;
        int              n;
        for (int i = 0; i < 16; i++) exp_mem[i] = '0;
        last_rd = '0;

        repeat (4) @(negedge clk);
        chk(done == 0 && err == 0, "R1", "done/err in reset", {30'd0, done, err}, 0);
        chk(phy_ctrl == '0, "R1", "control word in reset", 32'(phy_ctrl), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(rd_data == '0, "R1", "read data after reset", 32'(rd_data), 0);
        chk(phy_ctrl == '0 && !done, "R1", "idle after reset", 32'(phy_ctrl), 0);

        // sweep writes over every register with varied ack latency
        for (int a = 0; a < 16; a++) begin
            logic [PL_W-1:0] ad, wd;
            ad = 16'(a * 16'h1001) ^ 16'h0300;
            wd = 16'(a * 16'h0F0F) ^ 16'hA5A5;
            dly = a % 4;
            op(1'b1, ad, wd, 1'b0, e, rd, n);
            exp_mem[a] = wd;
            chk(e == 0, "R4", "write error flag", 32'(e), 0);
            chk(addr_cap == ad, "R3", "address captured by PHY", 32'(addr_cap), 32'(ad));
            chk(rd == last_rd, "R10", "read data held across write", 32'(rd), 32'(last_rd));
        end

        // read back with latency check
        for (int a = 0; a < 16; a++) begin
            dly = (a * 3) % 5;
            op(1'b0, 16'(a) | 16'h4440, '0, 1'b0, e, rd, n);
            chk(e == 0, "R5", "read error flag", 32'(e), 0);
            chk(rd == exp_mem[a], "R5", "read data", 32'(rd), 32'(exp_mem[a]));
            chk(n == lat_read(dly), "R6", "read latency", 32'(n), 32'(lat_read(dly)));
            last_rd = rd;
        end
        chk(prot_err == 0, "R3", "strobe ordering violations", 32'(prot_err), 0);

        // ack exactly at the last sample succeeds
        dly = (MX - 1) * G - 1;
        op(1'b0, 16'h0005, '0, 1'b0, e, rd, n);
        chk(e == 0, "R6", "ack at last sample", 32'(e), 0);
        chk(rd == exp_mem[5], "R6", "data at last sample", 32'(rd), 32'(exp_mem[5]));
        last_rd = rd;

        // one cycle later times out
        dly = (MX - 1) * G;
        op(1'b0, 16'h0009, '0, 1'b0, e, rd, n);
        chk(e == 1, "R6", "ack past last sample", 32'(e), 1);
        chk(n == 3 + (MX - 1) * G, "R6", "timeout latency", 32'(n), 32'(3 + (MX - 1) * G));
        chk(rd == last_rd, "R10", "read data held on timeout", 32'(rd), 32'(last_rd));
        dly = 0;
        repeat (60) @(negedge clk);

        // PHY never answers
        mode = 1;
        op(1'b1, 16'h0002, 16'hDEAD, 1'b0, e, rd, n);
        chk(e == 1, "R7", "dead PHY write error", 32'(e), 1);
        chk(n == 3 + (MX - 1) * G, "R7", "dead PHY latency", 32'(n), 32'(3 + (MX - 1) * G));

        // ack stuck high: address ack-low wait times out
        mode = 2;
        op(1'b0, 16'h0002, '0, 1'b0, e, rd, n);
        chk(e == 1, "R7", "stuck-high read error", 32'(e), 1);
        chk(n == 7 + (MX - 1) * G, "R7", "stuck-high latency", 32'(n), 32'(7 + (MX - 1) * G));
        chk(rd == last_rd, "R10", "read data held on stuck ack", 32'(rd), 32'(last_rd));
        mode = 0;
        repeat (20) @(negedge clk);

        // recovery after timeouts
        op(1'b0, 16'h0002, '0, 1'b0, e, rd, n);
        chk(e == 0 && rd == exp_mem[2], "R7", "read after recovery", 32'(rd), 32'(exp_mem[2]));
        last_rd = rd;

        // request raised while busy is ignored
        dly = 2;
        op(1'b1, 16'h0003, 16'h1234, 1'b1, e, rd, n);
        exp_mem[3] = 16'h1234;
        chk(e == 0, "R8", "write with poke", 32'(e), 0);
        op(1'b0, 16'h0003, '0, 1'b0, e, rd, n);
        chk(rd == 16'h1234, "R8", "target register", 32'(rd), 32'h1234);
        op(1'b0, 16'h000B, '0, 1'b0, e, rd, n);
        chk(rd == exp_mem[11], "R8", "poked register untouched", 32'(rd), 32'(exp_mem[11]));
        chk(prot_err == 0, "R4", "strobe ordering violations", 32'(prot_err), 0);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule